// File: doc/BRIEF.md
# Stereo DC-Blocking High-Pass Filter

This block strips the DC offset from a two-channel stream of 24-bit signed audio samples. Each accepted sample passes through a first-order recursive high-pass section, y[n] = x[n] - x[n-1] + a*y[n-1], with the pole a close to 0.9995. This gives a zero at DC and a corner far below the audio band. The left and right channels share one arithmetic datapath. Each channel keeps its own previous-input and previous-output state, and a tag that arrives with each sample selects which state is used.

A bypass input sends the raw sample to the output unchanged. The recursion keeps running in the background while bypass is set, so turning the filter back on continues from a settled state. All arithmetic is fixed point. The feedback value carries extra fractional bits, its product is truncated toward zero so small residues die out, and it is clamped rather than wrapped when a large step would overflow it.

Top module: `dcblock_hpf`

## Requirements
- R1: A synchronous active-high reset drives out_valid and out_data to zero and clears every channel's previous-input and previous-output state to zero. The first filtered sample on a channel after reset therefore equals that sample.
- R2: A sample accepted with in_valid high appears on the outputs exactly one clock later, with out_valid high and out_chan equal to the accepted tag. In a cycle after one without in_valid, out_valid is low and out_data and out_chan keep their previous values.
- R3: The feedback state S holds y scaled by 2^8. With P the previous input and S the previous state of the tagged channel, the new state is S' = clamp((x - P)*256 + T(S*A / 2^23)). The filtered output is T(S'/256). Here T truncates toward zero.
- R4: The pole coefficient A is 8384414 / 2^23, which is 0.9995 rounded to 23 fractional bits.
- R5: The clamp limits S' to the signed 32-bit range [-2^31, 2^31-1], so the output saturates at -8388608 and 8388607 and never wraps.
- R6: Because of the truncation toward zero, a constant input of either sign makes the filtered output decay to exactly 0 and stay there.
- R7: Tag 0 selects the left channel and tag 1 the right channel. A sample on one channel leaves the other channel's state untouched.
- R8: With bypass high, out_data equals in_data bit for bit.
- R9: The state of the tagged channel updates by the R3 rule whether or not bypass is high. After bypass is released, the output is the same as if filtering had never been off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 1 | Channel tag, 0 left, 1 right |
| in_data | input | 24 | Signed input sample |
| bypass | input | 1 | 1 passes samples through, 0 filters |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel tag of the output sample |
| out_data | output | 24 | Signed output sample |

## Verification
Every result is due one clock after its sample is strobed in: the output register is the only stage, and the state update happens on the same edge. The bench drives inputs on the falling edge. At the next falling edge, after exactly one rising edge, it compares the outputs with a behavioural model that uses 64-bit integer division for the truncation. Cycles without a strobe are checked for a low out_valid and held data. The long constant-input runs check that the output reaches exactly zero after the decay.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int DEF_DATA_W   = 24;
  localparam int DEF_FRAC_X   = 8;
  localparam int DEF_COEF_FR  = 23;
  localparam int DEF_COEF_VAL = 8384414;
  localparam int DEF_NUM_CH   = 2;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/dcb_state_bank.sv
module dcb_state_bank #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 24,
  parameter int ST_W   = 32,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         sel,
  input  logic signed [DATA_W-1:0] x_new,
  input  logic signed [ST_W-1:0]   s_new,
  output logic signed [DATA_W-1:0] x_prev,
  output logic signed [ST_W-1:0]   s_prev
);
  logic signed [DATA_W-1:0] x_q [NUM_CH];
  logic signed [ST_W-1:0]   s_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        x_q[i] <= '0;
        s_q[i] <= '0;
      end else if (wr_en && (sel == SEL_W'(i))) begin
        x_q[i] <= x_new;
        s_q[i] <= s_new;
      end
    end

    AST_OTHER_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (sel == SEL_W'(i))) |=> ($stable(x_q[i]) && $stable(s_q[i]))); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (x_q[i] == '0 && s_q[i] == '0)); // R1
  end

  always_comb begin
    x_prev = x_q[0];
    s_prev = s_q[0];
    for (int k = 1; k < NUM_CH; k++) begin
      if (sel == SEL_W'(k)) begin
        x_prev = x_q[k];
        s_prev = s_q[k];
      end
    end
  end
endmodule

// File: rtl/dcb_clamp.sv
module dcb_clamp #(
  parameter int IN_W  = 35,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    clipped
);
  localparam logic signed [IN_W-1:0] HI = IN_W'({1'b0, {(OUT_W-1){1'b1}}});
  localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);

  always_comb begin
    clipped = 1'b1;
    if (din > HI)      dout = HI[OUT_W-1:0];
    else if (din < LO) dout = LO[OUT_W-1:0];
    else begin
      dout    = din[OUT_W-1:0];
      clipped = 1'b0;
    end
  end
endmodule

// File: rtl/dcb_datapath.sv
module dcb_datapath #(
  parameter int DATA_W   = 24,
  parameter int FRAC_X   = 8,
  parameter int COEF_FR  = 23,
  parameter int COEF_VAL = 8384414,
  localparam int ST_W    = DATA_W + FRAC_X,
  localparam int ACC_W   = ST_W + 3,
  localparam int COEF_W  = COEF_FR + 1,
  localparam int PROD_W  = ST_W + COEF_W + 1
) (
  input  logic signed [DATA_W-1:0] x_cur,
  input  logic signed [DATA_W-1:0] x_prev,
  input  logic signed [ST_W-1:0]   s_prev,
  output logic signed [ST_W-1:0]   s_next,
  output logic signed [DATA_W-1:0] y_filt
);
  localparam logic [COEF_W-1:0]        COEF   = COEF_W'(COEF_VAL);
  localparam logic signed [PROD_W-1:0] P_BIAS = PROD_W'((64'd1 << COEF_FR) - 64'd1);
  localparam logic signed [ST_W:0]     O_BIAS = (ST_W+1)'((64'd1 << FRAC_X) - 64'd1);

  logic signed [PROD_W-1:0] s_ext, c_ext, prod, prod_b, quo;
  logic signed [ACC_W-1:0]  diff, diff_sh, fb, acc;
  logic signed [ST_W:0]     o_b, o_sh;
  logic                     clip_unused;

  always_comb begin
    s_ext   = PROD_W'(s_prev);
    c_ext   = PROD_W'($signed({1'b0, COEF}));
    prod    = s_ext * c_ext;
    prod_b  = prod[PROD_W-1] ? prod + P_BIAS : prod;
    quo     = prod_b >>> COEF_FR;
    fb      = quo[ACC_W-1:0];
    diff    = ACC_W'(x_cur) - ACC_W'(x_prev);
    diff_sh = diff <<< FRAC_X;
    acc     = diff_sh + fb;
  end

  dcb_clamp #(.IN_W(ACC_W), .OUT_W(ST_W)) u_clamp (
    .din(acc), .dout(s_next), .clipped(clip_unused));

  always_comb begin
    o_b    = (ST_W+1)'(s_next);
    if (s_next[ST_W-1]) o_b = o_b + O_BIAS;
    o_sh   = o_b >>> FRAC_X;
    y_filt = o_sh[DATA_W-1:0];
  end
endmodule

// File: rtl/dcblock_hpf.sv
module dcblock_hpf #(
  parameter int DATA_W   = dcb_pkg::DEF_DATA_W,
  parameter int FRAC_X   = dcb_pkg::DEF_FRAC_X,
  parameter int COEF_FR  = dcb_pkg::DEF_COEF_FR,
  parameter int COEF_VAL = dcb_pkg::DEF_COEF_VAL,
  parameter int NUM_CH   = dcb_pkg::DEF_NUM_CH,
  localparam int ST_W    = DATA_W + FRAC_X,
  localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEL_W-1:0]  in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic              bypass,
  output logic              out_valid,
  output logic [SEL_W-1:0]  out_chan,
  output logic [DATA_W-1:0] out_data
);
  logic signed [DATA_W-1:0] x_prev, y_filt;
  logic signed [ST_W-1:0]   s_prev, s_next;

  dcb_state_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ST_W(ST_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(in_valid), .sel(in_chan),
    .x_new($signed(in_data)), .s_new(s_next),
    .x_prev(x_prev), .s_prev(s_prev));

  dcb_datapath #(.DATA_W(DATA_W), .FRAC_X(FRAC_X), .COEF_FR(COEF_FR),
                 .COEF_VAL(COEF_VAL)) u_dp (
    .x_cur($signed(in_data)), .x_prev(x_prev), .s_prev(s_prev),
    .s_next(s_next), .y_filt(y_filt));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= bypass ? in_data : y_filt;
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data))); // R2
  AST_CHAN_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_chan == $past(in_chan))); // R7
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) |=> (out_data == $past(in_data))); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R1
endmodule

// File: tb/dcblock_hpf_tb.sv
`timescale 1ns/1ps
module dcblock_hpf_tb_top;
  localparam longint A_COEF = 8384414;
  localparam longint S_MAX  = 64'sd2147483647;
  localparam longint S_MIN  = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_chan = 1'b0;
  logic [23:0] in_data = '0;
  logic        bypass = 1'b0;
  logic        out_valid;
  logic        out_chan;
  logic [23:0] out_data;

  int checks = 0;
  int errors = 0;

  longint xp [2];
  longint st [2];
  bit     pend = 0;
  logic   exp_chan = 0;
  longint exp_data = 0;
  string  exp_tag = "R2";

  always #2 clk = ~clk;

  dcblock_hpf dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .bypass(bypass), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data));

  function automatic longint sx24(input logic [23:0] v);
    return longint'(signed'(v));
  endfunction

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic compare_now;
    checks++;
    if (pend) begin
      if (!out_valid || out_chan !== exp_chan || sx24(out_data) != exp_data) begin
        errors++;
        $display("FAIL %s: valid=%0b chan=%0d data=%0d expected valid=1 chan=%0d data=%0d",
                 exp_tag, out_valid, out_chan, sx24(out_data), exp_chan, exp_data);
      end
    end else begin
      if (out_valid || sx24(out_data) != exp_data) begin
        errors++;
        $display("FAIL R2: idle valid=%0b data=%0d expected valid=0 data=%0d",
                 out_valid, sx24(out_data), exp_data);
      end
    end
  endtask

  task automatic step(input bit v, input bit ch, input longint x, input bit byp, input string tag);
    longint d, q, s, y;
    @(negedge clk);
    compare_now();
    in_valid = v;
    in_chan  = ch;
    in_data  = 24'(x);
    bypass   = byp;
    pend     = v;
    if (v) begin
      d = (x - xp[ch]) * 256;
      q = (st[ch] * A_COEF) / 64'sd8388608;
      s = d + q;
      if (s > S_MAX) s = S_MAX;
      if (s < S_MIN) s = S_MIN;
      y = s / 256;
      xp[ch]   = x;
      st[ch]   = s;
      exp_chan = ch;
      exp_data = byp ? x : y;
      exp_tag  = tag;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
    $finish;
  end

  initial begin
    xp[0] = 0; xp[1] = 0; st[0] = 0; st[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state on the outputs
    checks++;
    if (out_valid !== 1'b0 || out_data !== 24'd0) begin
      errors++;
      $display("FAIL R1: valid=%0b data=%0d expected 0 0", out_valid, out_data);
    end
    rst = 1'b0;
    // R1 R3: first sample after reset equals input
    step(1, 0, 1000, 0, "R1");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R3");
    // R7: right channel untouched by left activity
    step(1, 1, -5000, 0, "R7");
    step(1, 1, -5000, 0, "R7");
    // R2: idle gaps
    step(0, 0, 0, 0, "R2");
    step(0, 1, 77, 0, "R2");
    // R3 R4: interleaved patterns
    for (int i = 0; i < 400; i++) begin
      step(1, 0, (i * 37117) % 900000 - 450000, 0, "R3");
      step(1, 1, 300000 - (i * 12345) % 600000, 0, "R4");
      if (i % 50 == 0) step(0, 0, 0, 0, "R2");
    end
    // R6: constant positive DC on left, constant negative on right
    for (int i = 0; i < 16000; i++) begin
      step(1, 0, 1000, 0, "R6");
      step(1, 1, -1000, 0, "R6");
    end
    step(1, 0, 1000, 0, "R6");
    step(1, 1, -1000, 0, "R6");
    step(0, 0, 0, 0, "R2");
    checks++;
    if (out_data !== 24'd0) begin
      errors++;
      $display("FAIL R6: data=%0d expected 0 after decay", sx24(out_data));
    end
    // R5: full-scale steps saturate both ways
    step(1, 0, -8388608, 0, "R5");
    step(1, 0, 8388607, 0, "R5");
    step(1, 0, -8388608, 0, "R5");
    step(1, 0, -8388608, 0, "R5");
    for (int i = 0; i < 20; i++) step(1, 0, ((i % 2) == 0) ? 8388607 : -8388608, 0, "R5");
    // R8 R9: bypass passes raw data, state keeps running
    for (int i = 0; i < 300; i++) begin
      step(1, i % 2, (i * 9973) % 4000000 - 2000000, 1, "R8");
    end
    for (int i = 0; i < 300; i++) begin
      step(1, i % 2, (i * 7919) % 3000000 - 1500000, 0, "R9");
    end
    // R3: pseudo-random mixture including bypass toggles and gaps
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 4) != 0, $urandom_range(0, 1),
           longint'($urandom_range(0, 16777215)) - 8388608,
           $urandom_range(0, 7) == 0, "R3");
    end
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    report();
    $finish;
  end
endmodule